// File: doc/BRIEF.md
# Dual-Channel Serial DAC Input Controller

This block is the digital receive side of a two-channel 12-bit converter. A host sends 16-bit words over three wires: an active-low frame sync, a serial clock and a data line. Data is captured on falling serial-clock edges, most significant bit first. Each word carries a channel select bit and a 12-bit code. The code is written into that channel's input register. A second rank of latches holds the codes that are presented to the converter cores.

The latches copy both input registers at the same moment. This happens when the active-low load input falls. If load is simply held low, it also happens when a frame completes. An active-low clear empties every register. A format input decides how the stored code is presented. When the format input is low the code passes unchanged. When it is high the most significant bit is inverted, so a twos complement value lands on the matching offset-binary level. All four serial and control inputs are asynchronous to the system clock. Each is brought through a two-flop synchroniser before any edge is detected.

Top module: `dual_dac_serial_front`

## Requirements
- R1: A frame is 16 bits received MSB first. Frame bits 15..13 have no effect on any output. Bit 12 selects the target channel (0 = channel A, 1 = channel B). Bits 11..0 become that channel's input-register code. The other channel's input register keeps its value.
- R2: While load is held high and steady, a completed frame changes no output code.
- R3: A falling edge on load copies both input registers into both output latches in the same clock cycle.
- R4: While load is held low, a completed frame updates both latches from the input registers, including the value just written.
- R5: Frame sync going high resets the bit counter. A frame cut short by sync rising before its 16th falling clock edge changes no register, and the next frame starts from bit 15.
- R6: While clear is low, both input registers and both latches are zero.
- R7: With the format input low, each output equals its latch. With it high, each output equals its latch with bit 11 inverted, so a cleared channel reads 0x800.
- R8: Falling serial-clock edges after the 16th within one frame are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock; data captured on its falling edge |
| fsync_n_i | input | 1 | Active-low frame sync |
| sdata_i | input | 1 | Serial data, MSB first |
| load_n_i | input | 1 | Active-low latch load; falling edge or held low |
| clear_n_i | input | 1 | Active-low clear of all registers |
| twos_fmt_i | input | 1 | 1 = twos complement presentation, 0 = straight binary |
| code_a_o | output | 12 | Channel A code to the converter core |
| code_b_o | output | 12 | Channel B code to the converter core |

## Verification
The assertions assume that every serial and control input stays at one level for several system clocks around each transition. They also assume that serial data is stable while the synchronised falling clock edge is detected, so that the synchronised data and clock describe the same bit. The stimulus keeps both conditions. It holds each serial clock phase for four system clocks and changes data only while the clock is high. It also holds the load and clear pulses for six system clocks. The format input is treated as a static configuration and is only changed between frames.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
    localparam int unsigned FRAME_W = 16;
    localparam int unsigned CODE_W  = 12;
    localparam int unsigned NUM_CH  = 2;
    // positions of the synchronised control inputs
    localparam int unsigned SY_SCLK  = 0;
    localparam int unsigned SY_FSYNC = 1;
    localparam int unsigned SY_SDATA = 2;
    localparam int unsigned SY_LOAD  = 3;
    localparam int unsigned SY_CLEAR = 4;
    localparam int unsigned SY_W     = 5;
endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
    parameter int unsigned W       = 5,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{s1: RST_VAL, s2: RST_VAL};
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.s2;
endmodule

// File: rtl/dacfe_frame_rx.sv
module dacfe_frame_rx #(
    parameter int unsigned FRAME_W = 16,
    parameter int unsigned CODE_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              fsync_n_s,
    input  logic              sdata_s,
    output logic              done_o,
    output logic              sel_o,
    output logic [CODE_W-1:0] payload_o
);
    localparam int unsigned CNT_W = $clog2(FRAME_W + 1);
    localparam int unsigned SH_W  = CODE_W + 1;   // select bit plus code; older bits fall off
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

    typedef struct packed {
        logic [SH_W-1:0]  shreg;
        logic [CNT_W-1:0] cnt;
        logic             sclk_prev;
        logic             done;
    } rx_st_t;

    rx_st_t st_d, st_q;
    logic   sclk_fall;

    always_comb begin
        sclk_fall    = st_q.sclk_prev & ~sclk_s;
        st_d         = st_q;
        st_d.done    = 1'b0;
        st_d.sclk_prev = sclk_s;
        if (fsync_n_s) begin
            st_d.cnt = '0;
        end else if (sclk_fall && (st_q.cnt < FULL)) begin
            st_d.shreg = {st_q.shreg[SH_W-2:0], sdata_s};
            st_d.cnt   = st_q.cnt + 1'b1;
            st_d.done  = (st_q.cnt == LAST);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{shreg: '0, cnt: '0, sclk_prev: 1'b1, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o    = st_q.done;
    assign sel_o     = st_q.shreg[CODE_W];
    assign payload_o = st_q.shreg[CODE_W-1:0];

    assert_sync_resets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fsync_n_s |=> (st_q.cnt == '0));
    assert_full_no_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == FULL) |=> !st_q.done);
    assert_done_after_last_R1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> (st_q.cnt == FULL));
endmodule

// File: rtl/dacfe_chan_regs.sv
module dacfe_chan_regs #(
    parameter int unsigned CODE_W = 12,
    parameter int unsigned NUM_CH = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_i,
    input  logic                          sel_i,
    input  logic [CODE_W-1:0]             payload_i,
    input  logic                          load_n_s,
    input  logic                          clear_n_s,
    output logic [NUM_CH-1:0][CODE_W-1:0] latch_o
);
    typedef struct packed {
        logic [NUM_CH-1:0][CODE_W-1:0] inr;
        logic [NUM_CH-1:0][CODE_W-1:0] lat;
        logic                          load_prev;
    } ch_st_t;

    ch_st_t st_d, st_q;
    logic   load_fall;

    always_comb begin
        load_fall      = st_q.load_prev & ~load_n_s;
        st_d           = st_q;
        st_d.load_prev = load_n_s;
        if (!clear_n_s) begin
            st_d.inr = '0;
            st_d.lat = '0;
        end else begin
            if (wr_i) begin
                st_d.inr[sel_i] = payload_i;
            end
            if (load_fall || (wr_i && !load_n_s)) begin
                st_d.lat = st_d.inr;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{inr: '0, lat: '0, load_prev: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign latch_o = st_q.lat;

    assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_n_s |=> ((st_q.inr == '0) && (st_q.lat == '0)));
    assert_hold_when_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_n_s && load_n_s) |=> $stable(st_q.lat));
    assert_load_edge_copies_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_fall && clear_n_s && !wr_i) |=> (st_q.lat == $past(st_q.inr)));
    assert_auto_update_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !sel_i && !load_n_s && clear_n_s) |=> (st_q.lat[0] == $past(payload_i)));
    assert_auto_update_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel_i && !load_n_s && clear_n_s) |=> (st_q.lat[1] == $past(payload_i)));
endmodule

// File: rtl/dual_dac_serial_front.sv
module dual_dac_serial_front
    import dacfe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              fsync_n_i,
    input  logic              sdata_i,
    input  logic              load_n_i,
    input  logic              clear_n_i,
    input  logic              twos_fmt_i,
    output logic [CODE_W-1:0] code_a_o,
    output logic [CODE_W-1:0] code_b_o
);
    localparam logic [SY_W-1:0] SY_IDLE = SY_W'(5'b11011);
    localparam logic [CODE_W-1:0] MSB_MASK = {1'b1, {(CODE_W-1){1'b0}}};

    logic [SY_W-1:0]               raw_in;
    logic [SY_W-1:0]               syn;
    logic                          wr;
    logic                          sel;
    logic [CODE_W-1:0]             payload;
    logic [NUM_CH-1:0][CODE_W-1:0] latches;
    logic [NUM_CH-1:0][CODE_W-1:0] codes;

    always_comb begin
        raw_in           = '0;
        raw_in[SY_SCLK]  = sclk_i;
        raw_in[SY_FSYNC] = fsync_n_i;
        raw_in[SY_SDATA] = sdata_i;
        raw_in[SY_LOAD]  = load_n_i;
        raw_in[SY_CLEAR] = clear_n_i;
    end

    dacfe_sync #(.W(SY_W), .RST_VAL(SY_IDLE)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (syn)
    );

    dacfe_frame_rx #(.FRAME_W(FRAME_W), .CODE_W(CODE_W)) i_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s    (syn[SY_SCLK]),
        .fsync_n_s (syn[SY_FSYNC]),
        .sdata_s   (syn[SY_SDATA]),
        .done_o    (wr),
        .sel_o     (sel),
        .payload_o (payload)
    );

    dacfe_chan_regs #(.CODE_W(CODE_W), .NUM_CH(NUM_CH)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (wr),
        .sel_i     (sel),
        .payload_i (payload),
        .load_n_s  (syn[SY_LOAD]),
        .clear_n_s (syn[SY_CLEAR]),
        .latch_o   (latches)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_fmt
        assign codes[ch] = twos_fmt_i ? (latches[ch] ^ MSB_MASK) : latches[ch];
    end

    assign code_a_o = codes[0];
    assign code_b_o = codes[1];

    assert_fmt_low_passes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!twos_fmt_i && !syn[SY_CLEAR]) |=> (twos_fmt_i || (code_a_o == '0 && code_b_o == '0)));
    assert_fmt_high_mid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (twos_fmt_i && !syn[SY_CLEAR]) |=> (!twos_fmt_i || (code_a_o == MSB_MASK && code_b_o == MSB_MASK)));
endmodule

// File: tb/test_dual_dac_serial_front.sv
module test_dual_dac_serial_front;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b1, fsync_n = 1'b1, sdata = 1'b0, load_n = 1'b1, clear_n = 1'b1, twos = 1'b0;
    logic [11:0] code_a, code_b;

    int n_tests = 0;
    int n_fail  = 0;
    bit done_flag = 0;

    logic [11:0] m_in_a = '0, m_in_b = '0, m_lat_a = '0, m_lat_b = '0;
    logic [23:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;   // 125 MHz

    dual_dac_serial_front i_dual_dac_serial_front (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .fsync_n_i(fsync_n), .sdata_i(sdata),
        .load_n_i(load_n), .clear_n_i(clear_n), .twos_fmt_i(twos),
        .code_a_o(code_a), .code_b_o(code_b)
    );

    function automatic logic [11:0] shown(input logic [11:0] v);
        return twos ? (v ^ 12'h800) : v;
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_now(input string tag);
        exp_q.push_back({shown(m_lat_a), shown(m_lat_b)});
        tag_q.push_back(tag);
        wait_clk(3);
    endtask

    // sends nbits of w (MSB first); extra bits beyond 16 are ones
    task automatic send(input logic [15:0] w, input int nbits);
        fsync_n = 1'b0;
        wait_clk(4);
        for (int i = 0; i < nbits; i++) begin
            sdata = (i < 16) ? w[15 - i] : 1'b1;
            wait_clk(4);
            sclk = 1'b0;
            wait_clk(4);
            sclk = 1'b1;
        end
        wait_clk(4);
        fsync_n = 1'b1;
        wait_clk(10);
        if (nbits >= 16) begin
            if (w[12]) m_in_b = w[11:0]; else m_in_a = w[11:0];
            if (!load_n) begin m_lat_a = m_in_a; m_lat_b = m_in_b; end
        end
    endtask

    task automatic pulse_load();
        load_n = 1'b0;
        wait_clk(6);
        load_n = 1'b1;
        wait_clk(10);
        m_lat_a = m_in_a;
        m_lat_b = m_in_b;
    endtask

    task automatic do_clear();
        clear_n = 1'b0;
        wait_clk(6);
        clear_n = 1'b1;
        wait_clk(6);
        m_in_a = '0; m_in_b = '0; m_lat_a = '0; m_lat_b = '0;
    endtask

    // monitor: compares queued expectations against the outputs
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                logic [23:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_tests++;
                if ({code_a, code_b} !== e) begin
                    n_fail++;
                    $display("FAIL %s: a=%h b=%h expected a=%h b=%h", t, code_a, code_b, e[23:12], e[11:0]);
                end
            end
        end
    end

    initial begin
        wait_clk(200000);
        if (!done_flag) begin
            done_flag = 1;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        expect_now("R6 reset state");

        send(16'h0123, 16);                 // channel A, load high
        expect_now("R2 no change while load high");
        pulse_load();
        expect_now("R3 load edge A");

        send(16'hFABC, 16);                 // ignored top bits set, channel B
        expect_now("R2 B written, latch holds");
        pulse_load();
        expect_now("R1 R3 load edge B, A kept");

        send(16'h0456, 16);
        send(16'h1789, 16);
        expect_now("R2 two writes held");
        pulse_load();
        expect_now("R3 both latches together");

        send(16'h0AAA, 10);                 // cut short
        expect_now("R5 short frame discarded");
        pulse_load();
        expect_now("R5 short frame left input regs");

        send(16'h1321, 20);                 // extra edges after bit 16
        pulse_load();
        expect_now("R8 extra edges ignored");

        load_n = 1'b0;                      // held low: auto update
        wait_clk(10);
        m_lat_a = m_in_a; m_lat_b = m_in_b;
        send(16'h0555, 16);
        expect_now("R4 auto update A");
        send(16'h1FFF, 16);
        expect_now("R4 auto update B");
        load_n = 1'b1;
        wait_clk(10);

        twos = 1'b1;
        wait_clk(2);
        expect_now("R7 msb inverted");

        do_clear();
        expect_now("R6 R7 clear gives mid-scale in twos mode");
        twos = 1'b0;
        wait_clk(2);
        expect_now("R6 R7 clear gives zero in binary mode");
        pulse_load();
        expect_now("R6 input regs cleared");

        wait_clk(10);
        if (!done_flag) begin
            done_flag = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule